// File: doc/BRIEF.md
# PHY Training Mailbox Reader

This block empties the message mailbox of a memory-interface training engine so that no processor has to poll it. It watches a one-bit mailbox status, reads a 16-bit low message half and a 16-bit high message half, and returns each message through an acknowledge output. The acknowledge is a two-phase handshake: the reader drops it, waits until the status reports the mailbox empty again, and then raises it.

Each top-level (major) message is sorted by its code. One code opens a streaming message, which carries a string index followed by a variable number of 32-bit argument words. Each of those words is assembled from both halves. One code ends training as passed and one ends it as failed. Any other code is shown and skipped. Every word read is shown on a data port with a one-cycle valid and a tag that says what kind of word it is. A start pulse arms the reader, and it returns to idle once a pass or fail code arrives.

Top module: `train_mbox_reader`

## Requirements
- R1: While reset is asserted and after it is released, `mb_ack` is high. `word_valid`, `done`, `pass` and `fail` are low, and no word is read until `start` is pulsed.
- R2: The reader waits while `mb_busy` is high. When `mb_busy` is low during a wait, it captures the word and shows it on `word_data` with `word_valid` high for exactly one cycle.
- R3: `mb_ack` falls in the cycle the word appears. It stays low for as long as `mb_busy` stays low, and it rises once `mb_busy` is seen high. Each word is acknowledged exactly once.
- R4: A major word is `mb_lo` zero-extended to 32 bits, whatever `mb_hi` holds. It is tagged 0.
- R5: A major code of 0x0008 is followed by an index word, read as `{mb_hi, mb_lo}` and tagged 1.
- R6: The low 16 bits of the index give the number N of argument words that follow. Each argument is read as `{mb_hi, mb_lo}` and tagged 2, and its value is never treated as a code. If N is 0, the next word is a major word.
- R7: A major code of 0x0007 gives a one-cycle pulse on `done` and `pass`. A major code of 0x00FF gives a one-cycle pulse on `done` and `fail`. In both cases the reader returns to idle.
- R8: Any other major code causes no pulse, and the next word is read as a major word.
- R9: A `start` pulse while a run is in progress has no effect on the word sequence.
- R10: In idle, a low `mb_busy` is not acted on: `mb_ack` stays high and no word is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that arms the reader |
| mb_busy | input | 1 | Mailbox status bit 0; low means a message is waiting |
| mb_lo | input | 16 | Low message half |
| mb_hi | input | 16 | High message half |
| mb_ack | output | 1 | Acknowledge to the mailbox, idle high |
| word_valid | output | 1 | One-cycle strobe for each word read |
| word_data | output | 32 | Word read |
| word_tag | output | 2 | 0 major, 1 index, 2 argument |
| done | output | 1 | Training ended (pulse) |
| pass | output | 1 | Training passed (pulse with done) |
| fail | output | 1 | Training failed (pulse with done) |

## Verification
The bench builds the reader with its default 16-bit halves and the default codes. Because argument counts are small, it can sweep every argument count from 0 to 5 along with a band of unknown major codes. The bench holds `mb_busy` low for several cycles after each capture, which exposes any early acknowledge. It places the pass and fail values inside argument words to show that they are not decoded there. It puts nonzero data on the high half during major words to show that major words ignore it.

// File: rtl/tmbx_pkg.sv
`timescale 1ns/1ps
package tmbx_pkg;

  // Word class; the encoding is the word_tag output value.
  typedef enum logic [1:0] {
    PH_MAJOR = 2'd0,
    PH_INDEX = 2'd1,
    PH_ARG   = 2'd2
  } phase_t;

  // Classification of a major code.
  typedef enum logic [1:0] {
    K_OTHER,
    K_STREAM,
    K_PASS,
    K_FAIL
  } kind_t;

endpackage

// File: rtl/tmbx_fetch.sv
`timescale 1ns/1ps
// Waits for a mailbox word, captures it and runs the two-phase acknowledge.
module tmbx_fetch #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              stream,
  input  logic              busy,
  input  logic [HALF_W-1:0] lo,
  input  logic [HALF_W-1:0] hi,
  output logic              ack,
  output logic              cap_valid,
  output logic [WORD_W-1:0] cap_data,
  output logic              fin
);

  typedef enum logic [1:0] {F_IDLE, F_WAIT, F_ACKLO} fst_t;
  fst_t st;

  // A stream word uses both halves. A major word uses only the low half.
  function automatic logic [WORD_W-1:0] join_halves(
    input logic s, input logic [HALF_W-1:0] h, input logic [HALF_W-1:0] l);
    return s ? {h, l} : {{HALF_W{1'b0}}, l};
  endfunction

  // Named events for the checks below.
  logic msg_ready;
  logic ack_clear;
  assign msg_ready = (st == F_WAIT) && !busy;
  assign ack_clear = (st == F_ACKLO) && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= F_IDLE;
      ack       <= 1'b1;
      cap_valid <= 1'b0;
      cap_data  <= '0;
      fin       <= 1'b0;
    end else begin
      cap_valid <= 1'b0;
      fin       <= 1'b0;
      unique case (st)
        F_IDLE: if (req) st <= F_WAIT;
        F_WAIT: if (msg_ready) begin
          cap_data  <= join_halves(stream, hi, lo);
          cap_valid <= 1'b1;
          ack       <= 1'b0;
          st        <= F_ACKLO;
        end
        F_ACKLO: if (ack_clear) begin
          ack <= 1'b1;
          fin <= 1'b1;
          st  <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // R2: a capture only follows a cycle in which the mailbox reported ready
  p_capture_on_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> !$past(busy));

  // R3: the acknowledge only falls together with a presented word
  p_ack_fall_with_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> cap_valid);

  // R3: the acknowledge stays low while the mailbox still reports a message
  p_ack_hold_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !busy) |=> !ack);

  // R3: the acknowledge only rises after the status was seen high
  p_ack_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(busy));

endmodule

// File: rtl/tmbx_seq.sv
`timescale 1ns/1ps
// Sequences major, index and argument words and reports the outcome.
module tmbx_seq
  import tmbx_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter logic [HALF_W-1:0] CODE_STREAM = 'h08,
  parameter logic [HALF_W-1:0] CODE_PASS   = 'h07,
  parameter logic [HALF_W-1:0] CODE_FAIL   = 'hff
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fin,
  input  logic [HALF_W-1:0] code,
  output logic              req,
  output logic              stream,
  output phase_t            phase,
  output logic              done,
  output logic              pass,
  output logic              fail
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} sst_t;
  sst_t st;
  logic [HALF_W-1:0] remain;

  function automatic kind_t classify(input logic [HALF_W-1:0] c);
    if (c == CODE_STREAM) return K_STREAM;
    if (c == CODE_PASS)   return K_PASS;
    if (c == CODE_FAIL)   return K_FAIL;
    return K_OTHER;
  endfunction

  // Named events.
  logic  word_done;
  logic  last_arg;
  kind_t kind;
  assign word_done = (st == S_WAIT) && fin;
  assign last_arg  = (remain == {{(HALF_W-1){1'b0}}, 1'b1});
  assign kind      = classify(code);

  assign req    = (st == S_REQ);
  assign stream = (phase != PH_MAJOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      phase  <= PH_MAJOR;
      remain <= '0;
      done   <= 1'b0;
      pass   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          phase <= PH_MAJOR;
          st    <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (word_done) begin
          st <= S_REQ;
          unique case (phase)
            PH_MAJOR: begin
              unique case (kind)
                K_STREAM: phase <= PH_INDEX;
                K_PASS: begin
                  done <= 1'b1;
                  pass <= 1'b1;
                  st   <= S_IDLE;
                end
                K_FAIL: begin
                  done <= 1'b1;
                  fail <= 1'b1;
                  st   <= S_IDLE;
                end
                default: phase <= PH_MAJOR;
              endcase
            end
            PH_INDEX: begin
              if (code == '0) begin
                phase <= PH_MAJOR;
              end else begin
                remain <= code;
                phase  <= PH_ARG;
              end
            end
            PH_ARG: begin
              remain <= remain - 1'b1;
              if (last_arg) phase <= PH_MAJOR;
            end
            default: phase <= PH_MAJOR;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: pass and fail never pulse together, and each pulses only with done
  p_outcome_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass, fail}));
  p_outcome_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass || fail));
  // R7: done lasts a single cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: the argument phase always has words left to read
  p_arg_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ARG) |-> (remain != '0));
  // R5: the word class is held while a word is in flight
  p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !fin) |=> $stable(phase));

endmodule

// File: rtl/train_mbox_reader.sv
`timescale 1ns/1ps
module train_mbox_reader
  import tmbx_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter logic [HALF_W-1:0] CODE_STREAM = 'h08,
  parameter logic [HALF_W-1:0] CODE_PASS   = 'h07,
  parameter logic [HALF_W-1:0] CODE_FAIL   = 'hff,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mb_busy,
  input  logic [HALF_W-1:0] mb_lo,
  input  logic [HALF_W-1:0] mb_hi,
  output logic              mb_ack,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [1:0]        word_tag,
  output logic              done,
  output logic              pass,
  output logic              fail
);

  logic   req;
  logic   stream;
  logic   fin;
  phase_t phase;

  tmbx_fetch #(.HALF_W(HALF_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .stream    (stream),
    .busy      (mb_busy),
    .lo        (mb_lo),
    .hi        (mb_hi),
    .ack       (mb_ack),
    .cap_valid (word_valid),
    .cap_data  (word_data),
    .fin       (fin)
  );

  tmbx_seq #(
    .HALF_W      (HALF_W),
    .CODE_STREAM (CODE_STREAM),
    .CODE_PASS   (CODE_PASS),
    .CODE_FAIL   (CODE_FAIL)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .fin    (fin),
    .code   (word_data[HALF_W-1:0]),
    .req    (req),
    .stream (stream),
    .phase  (phase),
    .done   (done),
    .pass   (pass),
    .fail   (fail)
  );

  assign word_tag = phase;

  // R4: a major word never carries upper-half data
  p_major_zero_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_tag == PH_MAJOR) |-> (word_data[WORD_W-1:HALF_W] == '0));

  // R10: nothing is shown once a run has ended
  p_no_word_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !word_valid);

endmodule

// File: tb/train_mbox_reader_test.sv
`timescale 1ns/1ps
module train_mbox_reader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mb_busy = 1'b1;
  logic [15:0] mb_lo = '0;
  logic [15:0] mb_hi = '0;
  logic        mb_ack, word_valid, done, pass, fail;
  logic [31:0] word_data;
  logic [1:0]  word_tag;

  train_mbox_reader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mb_busy(mb_busy),
    .mb_lo(mb_lo), .mb_hi(mb_hi), .mb_ack(mb_ack), .word_valid(word_valid),
    .word_data(word_data), .word_tag(word_tag), .done(done), .pass(pass), .fail(fail)
  );

  always #4 clk = ~clk;

  int vecs = 0;
  int errs = 0;
  logic [31:0] exp_d [0:1023];
  logic [1:0]  exp_t [0:1023];
  logic [31:0] obs_d [0:1023];
  logic [1:0]  obs_t [0:1023];
  int exp_n = 0;
  int obs_n = 0;
  int n_done = 0, n_pass = 0, n_fail = 0;
  int cyc = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (word_valid && obs_n < 1024) begin
        obs_d[obs_n] = word_data;
        obs_t[obs_n] = word_tag;
        obs_n = obs_n + 1;
      end
      if (done) n_done = n_done + 1;
      if (pass) n_pass = n_pass + 1;
      if (fail) n_fail = n_fail + 1;
    end
  end

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errs = errs + 1;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vecs = vecs + 1;
    if (act !== exp) begin
      errs = errs + 1;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic expect_word(input logic [31:0] d, input logic [1:0] t);
    exp_d[exp_n] = d;
    exp_t[exp_n] = t;
    exp_n = exp_n + 1;
  endtask

  // Mailbox model: hold busy, present the halves, wait for ack low,
  // keep busy low a while (R3: ack must stay low), then report empty.
  task automatic send_word(input logic [15:0] h, input logic [15:0] l);
    mb_hi = h;
    mb_lo = l;
    repeat (2) @(negedge clk);
    mb_busy = 1'b0;
    for (int g = 0; g < 1000 && mb_ack; g++) @(negedge clk);
    chk("R3 ack low on capture", {31'd0, mb_ack}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R3 ack held while busy low", {31'd0, mb_ack}, 32'd0);
    mb_busy = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 ack back high", {31'd0, mb_ack}, 32'd1);
  endtask

  task automatic send_major(input logic [15:0] code);
    expect_word({16'h0000, code}, 2'd0);        // R4: zero-extended, tag 0
    send_word(16'hBEEF, code);
  endtask

  task automatic send_stream(input int n);
    logic [15:0] ih;
    send_major(16'h0008);
    ih = 16'h1230 + 16'(n);
    expect_word({ih, 16'(n)}, 2'd1);            // R5: index tag 1
    send_word(ih, 16'(n));
    for (int k = 0; k < n; k++) begin
      logic [15:0] ah, al;
      ah = 16'(k) * 16'h0101 + 16'(n);
      al = 16'hC000 + 16'(k);
      expect_word({ah, al}, 2'd2);              // R6: argument tag 2
      send_word(ah, al);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic compare_words(input string rq);
    chk({rq, " word count"}, 32'(obs_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      chk({rq, " word data"}, obs_d[i], exp_d[i]);
      chk({rq, " word tag"}, {30'd0, obs_t[i]}, {30'd0, exp_t[i]});
    end
  endtask

  initial begin
    int d0, p0, f0, o0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 ack high in reset", {31'd0, mb_ack}, 32'd1);
    chk("R1 valid low in reset", {31'd0, word_valid}, 32'd0);
    chk("R1 done low in reset", {29'd0, done, pass, fail}, 32'd0);
    rst_n = 1'b1;
    mb_busy = 1'b0;               // R1: no read before start
    repeat (5) @(negedge clk);
    chk("R1 no read before start", {31'd0, mb_ack}, 32'd1);
    chk("R1 no word before start", 32'(obs_n), 32'd0);
    mb_busy = 1'b1;
    @(negedge clk);

    // Run A: unknown codes, stream sweep, pass.
    pulse_start();
    mb_lo = 16'h0007;
    repeat (10) @(negedge clk);
    chk("R2 waits while busy", 32'(obs_n), 32'd0);
    chk("R2 ack idle while busy", {31'd0, mb_ack}, 32'd1);
    for (int c = 1; c <= 6; c++) send_major(16'(c));          // R8
    send_major(16'h0009);                                     // R8
    send_major(16'h00FE);                                     // R8
    send_major(16'h0107);                                     // R8: not pass
    chk("R8 no end on other codes", 32'(n_done), 32'd0);
    for (int n = 0; n <= 5; n++) begin
      if (n == 2) pulse_start();                              // R9: ignored
      send_stream(n);
    end
    chk("R6 no end inside streams", 32'(n_done), 32'd0);
    send_major(16'h0007);
    repeat (3) @(negedge clk);
    chk("R7 one done on pass", 32'(n_done), 32'd1);
    chk("R7 one pass pulse", 32'(n_pass), 32'd1);
    chk("R7 no fail on pass", 32'(n_fail), 32'd0);
    compare_words("R9 run A");

    // R10: idle after done; a waiting message is not read.
    o0 = obs_n;
    mb_lo = 16'h0008;
    mb_busy = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 ack stays high in idle", {31'd0, mb_ack}, 32'd1);
    chk("R10 no word in idle", 32'(obs_n), 32'(o0));
    mb_busy = 1'b1;
    @(negedge clk);

    // Run B: argument words that look like codes, then fail.
    exp_n = 0;
    obs_n = 0;
    d0 = n_done; p0 = n_pass; f0 = n_fail;
    pulse_start();
    send_major(16'h0008);
    expect_word({16'h0000, 16'h0002}, 2'd1);
    send_word(16'h0000, 16'h0002);
    expect_word({16'h0000, 16'h0007}, 2'd2);                  // R6: not a pass
    send_word(16'h0000, 16'h0007);
    expect_word({16'h0001, 16'h00FF}, 2'd2);                  // R6: not a fail
    send_word(16'h0001, 16'h00FF);
    chk("R6 arguments not decoded", 32'(n_done - d0), 32'd0);
    send_stream(3);
    send_major(16'h00FF);
    repeat (3) @(negedge clk);
    chk("R7 one done on fail", 32'(n_done - d0), 32'd1);
    chk("R7 one fail pulse", 32'(n_fail - f0), 32'd1);
    chk("R7 no pass on fail", 32'(n_pass - p0), 32'd0);
    compare_words("R6 run B");

    // Run C: a major word with a set high half still passes.
    exp_n = 0;
    obs_n = 0;
    d0 = n_done; p0 = n_pass;
    pulse_start();
    expect_word({16'h0000, 16'h0007}, 2'd0);                  // R4
    send_word(16'hFFFF, 16'h0007);
    repeat (3) @(negedge clk);
    chk("R4 pass with high half set", 32'(n_pass - p0), 32'd1);
    compare_words("R4 run C");

    summary_and_end();
  end

endmodule